// File: doc/BRIEF.md
# Boundary-Scan Drive Strength Controller

This block sits next to a 1149.1 test access port. It holds the current test instruction and decodes it into the control flags that decide who owns the pins. Either the system logic owns the pin directions and levels, or the test logic does. The decode also raises an internal reset request, a keep-alive clock enable and a bypass-register select. The same block keeps a per-pin output-driver-strength selection, where each pin picks either a large or a small driver.

The strength selection has two sources. The system copy is loaded from a few configuration pins when system reset is released. A system-mode drive instruction can also overwrite it live from boundary-scan data. A test-mode drive instruction writes a sticky override instead. That override survives while the current instruction stays within a holding trio: the test-mode drive instruction, EXTEST and SHUTDOWN. Any other instruction, or test-logic-reset, returns the pins to the system copy. The TAP state machine, register shifting and pad cells live elsewhere. All state changes on the rising edge of the test clock.

Top module: `scan_drive_ctl`

## Requirements
- R1: Instruction codes are 3 bits: 3'b000 EXTEST, 3'b001 SHUTDOWN, 3'b010 test-mode drive, 3'b011 system-mode drive, 3'b100 manufacturing-reserved, 3'b111 BYPASS. Any other code is treated as BYPASS. A code takes effect on the edge where `ir_update` is high.
- R2: `test_owns_io` is high exactly when the current instruction is EXTEST, SHUTDOWN or test-mode drive.
- R3: `int_rst_req` and `keepalive_en` are high exactly when the current instruction is SHUTDOWN or test-mode drive.
- R4: `bypass_sel` is high exactly when the current instruction is BYPASS (including the unknown codes) or SHUTDOWN.
- R5: Outside the holding trio, a rising `sys_rst_n` loads `drv_small[i]` from `cfg_pins[i % CFG_W]` within 4 clock edges after the change is seen. In `drv_small`, bit value 0 selects the large driver and 1 selects the small driver.
- R6: Under system-mode drive, an `upd_dr` pulse copies `bs_drv` into `drv_small` on that edge, and all flags stay low.
- R7: Under test-mode drive, an `upd_dr` pulse copies `bs_drv` into `drv_small` on that edge.
- R8: While the instruction stays in the holding trio, `drv_small` keeps its value. It is not changed by a system reset release, and it is not changed by `upd_dr` under EXTEST or SHUTDOWN.
- R9: When an instruction outside the trio becomes current, `drv_small` returns to the system copy. The system copy is the last configuration load or system-mode update.
- R10: A `tlr` pulse makes BYPASS current. It clears ownership, reset request and keep-alive, and it returns `drv_small` to the system copy.
- R11: The manufacturing-reserved instruction keeps all of `test_owns_io`, `int_rst_req`, `keepalive_en` and `bypass_sel` low. A system reset release under it loads the configuration as in normal operation.
- R12: While `rst` is high, the instruction is BYPASS, `bypass_sel` is 1, the other flags are 0, and `drv_small` takes `DRV_RST`, which is all zeros (large) by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high TAP reset |
| ir_code | input | 3 | Instruction code presented for update |
| ir_update | input | 1 | Instruction update strobe |
| tlr | input | 1 | Test-logic-reset state strobe |
| upd_dr | input | 1 | Update-DR state strobe |
| bs_drv | input | NPIN | Drive-select bits from the boundary-scan register |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| cfg_pins | input | CFG_W | Configuration pins sampled at reset release |
| drv_small | output | NPIN | Per-pin driver select, 1 = small |
| test_owns_io | output | 1 | Test logic owns pin directions and levels |
| int_rst_req | output | 1 | Internal system reset request |
| keepalive_en | output | 1 | Keep-alive clock enable |
| bypass_sel | output | 1 | Bypass register selected |

## Verification
The hardest state to reach from the ports is a sticky test override whose value differs from the system copy. The test then has to show that the override survives when the instruction moves across the trio, and that it is dropped only on leaving the trio. The bench first sets up a known system copy through a configuration release. It then writes a different pattern under test-mode drive and steps through EXTEST and SHUTDOWN. During those steps it applies both a scan update and a full system reset release, and neither may disturb the pins. Finally it leaves the trio, either through a non-trio instruction or through test-logic-reset, and checks that the older system pattern reappears.

// File: rtl/scan_drive_pkg.sv
package scan_drive_pkg;
  localparam int IR_W = 3;

  typedef enum logic [IR_W-1:0] {
    INS_EXTEST   = 3'b000,
    INS_SHUTDOWN = 3'b001,
    INS_DRVT     = 3'b010,
    INS_DRVS     = 3'b011,
    INS_PRIV     = 3'b100,
    INS_BYPASS   = 3'b111
  } ins_e;

  typedef struct packed {
    logic test_own;
    logic rst_req;
    logic keepalive;
    logic bypass;
  } mode_t;

  function automatic ins_e decode_ins(input logic [IR_W-1:0] code);
    case (code)
      3'b000:  return INS_EXTEST;
      3'b001:  return INS_SHUTDOWN;
      3'b010:  return INS_DRVT;
      3'b011:  return INS_DRVS;
      3'b100:  return INS_PRIV;
      default: return INS_BYPASS;
    endcase
  endfunction

  // instructions under which the selected drive strength is frozen
  function automatic logic holds_drive(input ins_e ins);
    return (ins == INS_EXTEST) || (ins == INS_SHUTDOWN) || (ins == INS_DRVT);
  endfunction

  function automatic mode_t mode_of(input ins_e ins);
    mode_t m;
    m.test_own  = holds_drive(ins);
    m.rst_req   = (ins == INS_SHUTDOWN) || (ins == INS_DRVT);
    m.keepalive = (ins == INS_SHUTDOWN) || (ins == INS_DRVT);
    m.bypass    = (ins == INS_BYPASS) || (ins == INS_SHUTDOWN);
    return m;
  endfunction
endpackage

// File: rtl/scan_drive_ir.sv
module scan_drive_ir
  import scan_drive_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ir_update,
  input  logic            tlr,
  input  logic [IR_W-1:0] ir_code,
  output ins_e            cur_q,
  output ins_e            nxt,
  output mode_t           mode_q
);
  always_comb begin
    if (tlr)            nxt = INS_BYPASS;
    else if (ir_update) nxt = decode_ins(ir_code);
    else                nxt = cur_q;
  end

  // flags are registered from the next instruction so they move with it
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= INS_BYPASS;
      mode_q <= mode_of(INS_BYPASS);
    end else begin
      cur_q  <= nxt;
      mode_q <= mode_of(nxt);
    end
  end
endmodule

// File: rtl/scan_drive_relsync.sv
module scan_drive_relsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/scan_drive_latch.sv
module scan_drive_latch
  import scan_drive_pkg::*;
#(
  parameter int              NPIN    = 8,
  parameter int              CFG_W   = 3,
  parameter logic [NPIN-1:0] DRV_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  ins_e             cur,
  input  ins_e             nxt,
  input  logic             rel,
  input  logic             upd_dr,
  input  logic [NPIN-1:0]  bs_drv,
  input  logic [CFG_W-1:0] cfg_pins,
  output logic [NPIN-1:0]  drv_q
);
  logic [NPIN-1:0] cfg_map;
  logic [NPIN-1:0] sys_q, sys_nxt, drv_nxt;
  logic            drvs_upd, drvt_upd;

  for (genvar i = 0; i < NPIN; i++) begin : g_map
    assign cfg_map[i] = cfg_pins[i % CFG_W];
  end

  assign drvs_upd = upd_dr && (cur == INS_DRVS);
  assign drvt_upd = upd_dr && (cur == INS_DRVT);

  always_comb begin
    if (drvs_upd)                      sys_nxt = bs_drv;
    else if (rel && !holds_drive(cur)) sys_nxt = cfg_map;
    else                               sys_nxt = sys_q;
  end

  always_comb begin
    if (holds_drive(nxt)) drv_nxt = drvt_upd ? bs_drv : drv_q;
    else                  drv_nxt = sys_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q <= DRV_RST;
      drv_q <= DRV_RST;
    end else begin
      sys_q <= sys_nxt;
      drv_q <= drv_nxt;
    end
  end
endmodule

// File: rtl/scan_drive_ctl.sv
module scan_drive_ctl
  import scan_drive_pkg::*;
#(
  parameter int              NPIN        = 8,
  parameter int              CFG_W       = 3,
  parameter int              SYNC_STAGES = 2,
  parameter logic [NPIN-1:0] DRV_RST     = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       ir_code,
  input  logic             ir_update,
  input  logic             tlr,
  input  logic             upd_dr,
  input  logic [NPIN-1:0]  bs_drv,
  input  logic             sys_rst_n,
  input  logic [CFG_W-1:0] cfg_pins,
  output logic [NPIN-1:0]  drv_small,
  output logic             test_owns_io,
  output logic             int_rst_req,
  output logic             keepalive_en,
  output logic             bypass_sel
);
  ins_e  cur_q, nxt;
  mode_t mode_q;
  logic  rel;

  scan_drive_ir u_ir (
    .clk(clk), .rst(rst), .ir_update(ir_update), .tlr(tlr),
    .ir_code(ir_code), .cur_q(cur_q), .nxt(nxt), .mode_q(mode_q)
  );

  scan_drive_relsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(sys_rst_n), .rise(rel)
  );

  scan_drive_latch #(.NPIN(NPIN), .CFG_W(CFG_W), .DRV_RST(DRV_RST)) u_latch (
    .clk(clk), .rst(rst), .cur(cur_q), .nxt(nxt), .rel(rel),
    .upd_dr(upd_dr), .bs_drv(bs_drv), .cfg_pins(cfg_pins), .drv_q(drv_small)
  );

  assign test_owns_io = mode_q.test_own;
  assign int_rst_req  = mode_q.rst_req;
  assign keepalive_en = mode_q.keepalive;
  assign bypass_sel   = mode_q.bypass;
endmodule

// File: rtl/scan_drive_ctl_chk.sv
module scan_drive_ctl_chk
  import scan_drive_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      ir_code,
  input logic            ir_update,
  input logic            tlr,
  input logic            upd_dr,
  input logic [NPIN-1:0] bs_drv,
  input logic [NPIN-1:0] drv_small,
  input logic            test_owns_io,
  input logic            int_rst_req,
  input logic            keepalive_en,
  input logic            bypass_sel,
  input ins_e            cur_ins
);
  assert_unknown_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    (ir_update && !tlr && (ir_code == 3'b101 || ir_code == 3'b110))
      |=> (bypass_sel && cur_ins == INS_BYPASS));

  assert_keepalive_owned_R3: assert property (@(posedge clk) disable iff (rst)
    keepalive_en |-> (int_rst_req && test_owns_io));

  assert_drvs_load_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_ins == INS_DRVS && upd_dr && !ir_update && !tlr)
      |=> (drv_small == $past(bs_drv)));

  assert_drvt_load_R7: assert property (@(posedge clk) disable iff (rst)
    (cur_ins == INS_DRVT && upd_dr && !ir_update && !tlr)
      |=> (drv_small == $past(bs_drv)));

  assert_trio_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (test_owns_io && !ir_update && !tlr && !(cur_ins == INS_DRVT && upd_dr))
      |=> $stable(drv_small));

  assert_tlr_release_R10: assert property (@(posedge clk) disable iff (rst)
    tlr |=> (bypass_sel && !test_owns_io && !int_rst_req && !keepalive_en));

  assert_private_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (cur_ins == INS_PRIV) |-> (!test_owns_io && !int_rst_req && !bypass_sel));
endmodule

bind scan_drive_ctl scan_drive_ctl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .ir_code(ir_code), .ir_update(ir_update), .tlr(tlr),
  .upd_dr(upd_dr), .bs_drv(bs_drv), .drv_small(drv_small),
  .test_owns_io(test_owns_io), .int_rst_req(int_rst_req),
  .keepalive_en(keepalive_en), .bypass_sel(bypass_sel), .cur_ins(cur_q)
);

// File: tb/tb_scan_drive_ctl.sv
module tb_scan_drive_ctl;
  localparam int NPIN  = 8;
  localparam int CFG_W = 3;

  logic clk = 0;
  logic rst = 1;
  logic [2:0] ir_code = 3'b111;
  logic ir_update = 0, tlr = 0, upd_dr = 0;
  logic [NPIN-1:0] bs_drv = '0;
  logic sys_rst_n = 0;
  logic [CFG_W-1:0] cfg_pins = '0;
  logic [NPIN-1:0] drv_small;
  logic test_owns_io, int_rst_req, keepalive_en, bypass_sel;

  int n_chk = 0, n_bad = 0;
  logic [NPIN-1:0] sys_exp = '0;

  always #10 clk = ~clk;

  scan_drive_ctl #(.NPIN(NPIN), .CFG_W(CFG_W)) dut (
    .clk(clk), .rst(rst), .ir_code(ir_code), .ir_update(ir_update), .tlr(tlr),
    .upd_dr(upd_dr), .bs_drv(bs_drv), .sys_rst_n(sys_rst_n), .cfg_pins(cfg_pins),
    .drv_small(drv_small), .test_owns_io(test_owns_io), .int_rst_req(int_rst_req),
    .keepalive_en(keepalive_en), .bypass_sel(bypass_sel)
  );

  function automatic logic [NPIN-1:0] cfg_to_drv(input logic [CFG_W-1:0] c);
    logic [NPIN-1:0] v;
    for (int i = 0; i < NPIN; i++) v[i] = c[i % CFG_W];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic own, input logic rq, input logic byp);
    chk(req, {28'd0, test_owns_io, int_rst_req, keepalive_en, bypass_sel},
        {28'd0, own, rq, rq, byp});
  endtask

  task automatic ir_load(input logic [2:0] c);
    @(negedge clk); ir_code = c; ir_update = 1;
    @(negedge clk); ir_update = 0;
  endtask

  task automatic dr_load(input logic [NPIN-1:0] v);
    @(negedge clk); bs_drv = v; upd_dr = 1;
    @(negedge clk); upd_dr = 0;
  endtask

  task automatic sys_release(input logic [CFG_W-1:0] c);
    @(negedge clk); sys_rst_n = 0; cfg_pins = c;
    repeat (3) @(negedge clk);
    sys_rst_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_flags("R12 flags", 0, 0, 1);
    chk("R12 drv", drv_small, 0);
  endtask

  task automatic t_decode;
    logic [2:0] codes [8] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};
    for (int k = 0; k < 8; k++) begin
      logic own, rq, byp;
      ir_load(codes[k]);
      own = (codes[k] <= 3'b010);                        // R2
      rq  = (codes[k] == 3'b001) || (codes[k] == 3'b010); // R3
      byp = (codes[k] == 3'b001) || (codes[k] >= 3'b101); // R4, R1
      chk_flags($sformatf("R1 R2 R3 R4 code %0d", codes[k]), own, rq, byp);
    end
    ir_load(3'b111);
  endtask

  task automatic t_release;
    sys_release(3'b101); sys_exp = cfg_to_drv(3'b101);
    chk("R5 cfg 101", drv_small, sys_exp);
    sys_release(3'b010); sys_exp = cfg_to_drv(3'b010);
    chk("R5 cfg 010", drv_small, sys_exp);
  endtask

  task automatic t_drvs;
    ir_load(3'b011);
    chk_flags("R6 flags", 0, 0, 0);
    dr_load(8'hC3); sys_exp = 8'hC3;
    chk("R6 load C3", drv_small, 8'hC3);
    dr_load(8'h1E); sys_exp = 8'h1E;
    chk("R6 load 1E", drv_small, 8'h1E);
  endtask

  task automatic t_drvt;
    ir_load(3'b010);
    chk("R8 enter keeps", drv_small, sys_exp);
    dr_load(8'hA5);
    chk("R7 override", drv_small, 8'hA5);
    ir_load(3'b000);
    dr_load(8'h3C);
    chk("R8 extest upd", drv_small, 8'hA5);
    ir_load(3'b001);
    sys_release(3'b111);
    chk("R8 shutdown release", drv_small, 8'hA5);
    ir_load(3'b111);
    chk("R9 back to system", drv_small, sys_exp);
  endtask

  task automatic t_tlr;
    ir_load(3'b010);
    dr_load(8'hFF);
    chk("R7 override FF", drv_small, 8'hFF);
    @(negedge clk); tlr = 1;
    @(negedge clk); tlr = 0;
    chk_flags("R10 flags", 0, 0, 1);
    chk("R10 drv", drv_small, sys_exp);
  endtask

  task automatic t_private;
    ir_load(3'b100);
    chk_flags("R11 flags", 0, 0, 0);
    sys_release(3'b011); sys_exp = cfg_to_drv(3'b011);
    chk("R11 release", drv_small, sys_exp);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_decode();
    t_release();
    t_drvs();
    t_drvt();
    t_tlr();
    t_private();
    finish_run();
  end
endmodule